// File: doc/BRIEF.md
# Overlapping 1010 Serial Pattern Detector

This block watches a serial bit stream that delivers one bit per clock. It raises a one-bit match flag whenever the four most recent bits, oldest first, read 1, 0, 1, 0. Matches may overlap: the closing "1 0" of one match can also open the next one, so the stream 1 0 1 0 1 0 gives two matches. Typical uses are frame alignment and combination-lock style entry checks.

The flag is Mealy-style. It depends on the current state and on the bit presented in the same cycle, so it goes high during the cycle in which the final 0 is on the input. The state assignment carries no numeric meaning. The machine uses the minimal set of four states that remains after equivalent states are merged: no prefix seen, "1", "10" and "101". A synchronous reset returns it to the state with no prefix seen.

Top module: `pattern_det_top`

## Requirements
- R1: While `rst` is high, and during the first three bits presented after reset is released, `matchOut` is 0.
- R2: `matchOut` is 1 in the same cycle as a 0 is presented on `serialIn`, provided the three preceding bits accepted since reset were 1, 0, 1 (oldest first).
- R3: Matches overlap: for the input 1,0,1,0,1,0 the flag is 1 on the 4th and 6th bits.
- R4: `matchOut` is 0 in every cycle not covered by R2, including every cycle in which `serialIn` is 1.
- R5: For the stream 0101011001010100 (first bit first), `matchOut` is 1 on the 5th, 13th and 15th bits only.
- R6: Asserting `rst` for one clock in the middle of a partial pattern discards it: after 1,0,1 and a reset cycle, a following 0 gives no match.
- R7: A run of several 1s keeps a valid leading 1: for the input 1,1,0,1,0 the flag is 1 only on the 5th bit.
- R8: A second consecutive 0 breaks a partial pattern: for the input 1,0,0,1,0,1,0 the flag is 1 only on the 7th bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the bit on `serialIn` is accepted at the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial data bit for the current cycle |
| matchOut | output | 1 | High while the presented bit completes 1010 |

## Verification
The bound checker keeps its own three-bit history and a count of the bits accepted since reset. On every cycle it checks that the flag equals the pattern condition (R2, R4), that the flag stays silent right after reset (R1), and that a match followed by a 1 re-arms a match on the next 0 (R3). Only the bench's directed scenarios can show the behaviour on the fixed reference stream (R5), the effect of a reset in the middle of a pattern (R6), and the recovery orderings R7 and R8. These scenarios are checked against a behavioural queue model alongside long random streams.

// File: rtl/pattern_det_pkg.sv
package pattern_det_pkg;

  // Reduced state set: each state names the longest useful suffix seen.
  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_ONE  = 2'd1,
    ST_OZ   = 2'd2,
    ST_OZO  = 2'd3
  } detState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic armed;   // three-bit prefix 1,0,1 held
    logic idle;    // no prefix held
  } ctrlStrobes_t;

endpackage

// File: rtl/pattern_det_ctrl.sv
module pattern_det_ctrl
  import pattern_det_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         serialIn,
  output ctrlStrobes_t strobes
);

  detState_t curState;
  detState_t nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_NONE: nextState = serialIn ? ST_ONE : ST_NONE;
      ST_ONE:  nextState = serialIn ? ST_ONE : ST_OZ;
      ST_OZ:   nextState = serialIn ? ST_OZO : ST_NONE;
      ST_OZO:  nextState = serialIn ? ST_ONE : ST_OZ;   // match folds back to "10"
      default: nextState = ST_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_NONE;
    else     curState <= nextState;
  end

  always_comb begin
    strobes.armed = (curState == ST_OZO);
    strobes.idle  = (curState == ST_NONE);
  end

endmodule

// File: rtl/pattern_det_dp.sv
module pattern_det_dp
  import pattern_det_pkg::*;
(
  input  logic         rst,
  input  logic         serialIn,
  input  ctrlStrobes_t strobes,
  output logic         matchOut
);

  // Mealy output: armed prefix plus a closing zero in this cycle.
  always_comb begin
    matchOut = strobes.armed & ~serialIn & ~rst & ~strobes.idle;
  end

endmodule

// File: rtl/pattern_det_top.sv
module pattern_det_top
  import pattern_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic matchOut
);

  ctrlStrobes_t strobes;

  pattern_det_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .strobes  (strobes)
  );

  pattern_det_dp dp_i (
    .rst      (rst),
    .serialIn (serialIn),
    .strobes  (strobes),
    .matchOut (matchOut)
  );

endmodule

// File: rtl/pattern_det_chk.sv
module pattern_det_chk (
  input logic clk,
  input logic rst,
  input logic serialIn,
  input logic matchOut
);

  logic [2:0] hist;
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= 3'b000;
      seen <= 2'd0;
    end else begin
      hist <= {hist[1:0], serialIn};
      if (seen != 2'd3) seen <= seen + 2'd1;
    end
  end

  // R2: a full pattern must raise the flag
  p_match_r2: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && hist == 3'b101 && !serialIn) |-> matchOut);

  // R4: the flag needs a full pattern and a zero input
  p_no_false_r4: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> (seen == 2'd3 && hist == 3'b101 && !serialIn));

  // R1: silent on the first bit after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !matchOut);

  // R3: a match followed by 1 re-arms on the next 0
  p_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    (matchOut ##1 serialIn) |=> (matchOut == !serialIn));

endmodule

bind pattern_det_top pattern_det_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .serialIn (serialIn),
  .matchOut (matchOut)
);

// File: tb/pattern_det_top_tb.sv
module pattern_det_top_tb_top;

  logic clk = 1'b0;
  logic rst;
  logic serialIn;
  logic matchOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int model[$];

  always #2 clk = ~clk;   // 250 MHz

  pattern_det_top dut_i (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .matchOut (matchOut)
  );

  function automatic bit modelExpect(input bit b);
    int n = model.size();
    if (n < 3) return 1'b0;
    return (model[n-3] == 1 && model[n-2] == 0 && model[n-1] == 1 && b == 1'b0);
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: matchOut=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at negedge, sample before the next rising edge, then advance model.
  task automatic sendBit(input bit b, input int scen, input string req);
    @(negedge clk);
    rst = 1'b0;
    serialIn = b;
    #1;
    check(matchOut, modelExpect(b), "model");
    if (scen >= 0) check(matchOut, scen[0], req);
    @(posedge clk);
    model.push_back(b);
    if (model.size() > 3) void'(model.pop_front());
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    serialIn = 1'b0;
    #1;
    check(matchOut, 1'b0, "R1 during reset");
    @(posedge clk);
    model.delete();
  endtask

  task automatic runSeq(input string bits, input string hits, input string req);
    for (int i = 0; i < bits.len(); i++)
      sendBit(bits[i] == "1", (hits[i] == "1") ? 1 : 0, req);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    serialIn = 1'b0;
    repeat (2) @(posedge clk);
    doReset();
    // R1: leading 1,0 pairs cannot match in the first three bits
    runSeq("010", "000", "R1 first bits");
    doReset();
    // R2: basic match
    runSeq("1010", "0001", "R2 basic");
    doReset();
    // R3: overlap
    runSeq("101010", "000101", "R3 overlap");
    doReset();
    // R5: reference stream
    runSeq("0101011001010100", "0000100000001010", "R5 stream");
    doReset();
    // R6: reset in the middle of a prefix
    runSeq("101", "000", "R6 prefix");
    doReset();
    runSeq("0", "0", "R6 after reset");
    doReset();
    // R7: run of ones
    runSeq("11010", "00001", "R7 ones");
    doReset();
    // R8: double zero breaks prefix
    runSeq("1001010", "0000001", "R8 double zero");
    doReset();
    // R4: ones never match; long random run with occasional resets
    runSeq("1111", "0000", "R4 ones");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) doReset();
      else sendBit($urandom_range(0, 1), -1, "R4 random");
    end
    finish();
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: expired expected=completion");
    finish();
  end

endmodule